// File: doc/BRIEF.md
# Modulo Data Address Generator

This block forms the X and Y data-bus addresses for a DSP core whose parallel data moves reach two memories at once. For each side the core presents the pointer registers, an index register, a pointer select, an update mode and a move strobe. The block drives the bus address from the selected pointer as it stands before the update. It also returns the value to write back into that pointer: the pointer plus 2, the pointer plus the index, or nothing at all when the move leaves the pointer unchanged.

A pair of bound registers turns any side into a circular buffer when that side's enable is set. The start bound and the end bound are loaded together by one 32-bit write. When an updating move finds that its pre-update pointer equals the end bound, the write-back value is the start bound instead of the stepped value. Only bits 15 to 1 take part in this compare and reload, so the largest ring is 64 KB. The X and Y sides share the bounds but have separate enables, and they act independently.

Top module: `modulo_agu`

## Requirements
- R1: After reset both bounds are zero, so an enabled updating move from pointer 0x00000000 wraps and writes back 0x00000000.
- R2: A write with `bnd_wr` high loads the end bound from `bnd_wdata[31:16]` and the start bound from `bnd_wdata[15:0]`. Moves see the new bounds from the next clock cycle on, and the old bounds in the cycle of the write.
- R3: Mode 2'b01 writes back the selected pointer plus 2, with the carry running through all 32 bits.
- R4: Mode 2'b10 writes back the selected pointer plus the side's 32-bit index.
- R5: Modes 2'b00 and 2'b11 leave the pointer unchanged. `wb_en` stays low and no wrap occurs, even when the pointer equals the end bound.
- R6: On an updating move with the side enabled, a pre-update pointer whose bits 15:1 equal bits 15:1 of the end bound raises `wrap`, and the write-back bits 15:1 take the start bound's bits 15:1.
- R7: On a wrap, write-back bits 31:16 and bit 0 keep the pre-update pointer's values.
- R8: Bit 0 of the pointer, of the end bound and of the start bound does not affect the compare or the reloaded bits.
- R9: With the side's enable low, the write-back is always the stepped value and `wrap` stays low.
- R10: The X and Y sides decide their wraps independently, so both can wrap in the same cycle, and an enable on one side does not affect the other.
- R11: The bus address is the low 16 bits of the selected pointer before the update.
- R12: With the move strobe low, `wb_en` and `wrap` stay low.
- R13: The select input picks the pointer (0 = first, 1 = second), and `wb_sel` returns the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_wr | input | 1 | Load both bounds |
| bnd_wdata | input | 32 | End bound [31:16], start bound [15:0] |
| x_mod_en | input | 1 | Ring enable, X side |
| y_mod_en | input | 1 | Ring enable, Y side |
| x_mv | input | 1 | X move executes this cycle |
| x_sel | input | 1 | X pointer select |
| x_mode | input | 2 | X update mode |
| x_ptrs | input | 64 | X pointers, second in [63:32], first in [31:0] |
| x_idx | input | 32 | X index register |
| y_mv | input | 1 | Y move executes this cycle |
| y_sel | input | 1 | Y pointer select |
| y_mode | input | 2 | Y update mode |
| y_ptrs | input | 64 | Y pointers, second in [63:32], first in [31:0] |
| y_idx | input | 32 | Y index register |
| x_addr | output | 16 | X bus address |
| x_wb_data | output | 32 | X pointer write-back value |
| x_wb_en | output | 1 | X pointer write-back strobe |
| x_wb_sel | output | 1 | X pointer to write back |
| x_wrap | output | 1 | X wrap taken |
| y_addr | output | 16 | Y bus address |
| y_wb_data | output | 32 | Y pointer write-back value |
| y_wb_en | output | 1 | Y pointer write-back strobe |
| y_wb_sel | output | 1 | Y pointer to write back |
| y_wrap | output | 1 | Y wrap taken |

## Verification
The hardest case to reach is a wrap whose outcome depends on bits that the compare ignores. That means a pointer or end bound with bit 0 set, or a pointer with nonzero upper bits, where a wrong design would still give the right low bits. The vector table aims pointers at the end bound with odd bit 0, with upper halfword patterns and with index steps. A directed case then rewrites the bounds with bit 0 set in both. A second hard case is the single cycle in which a bounds write is pending. The bench applies a move at the end bound in that same cycle and expects the old bounds, then repeats the move after the edge and expects the new ones.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'b00,
    UPD_INC2  = 2'b01,
    UPD_INDEX = 2'b10,
    UPD_RSVD  = 2'b11
  } upd_mode_e;

  function automatic logic is_update(input upd_mode_e m);
    return (m == UPD_INC2) || (m == UPD_INDEX);
  endfunction

endpackage

// File: rtl/modulo_bounds.sv
module modulo_bounds #(
  parameter int MOD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [2*MOD_W-1:0] wdata,
  output logic [MOD_W-2:0]   start_hi,
  output logic [MOD_W-2:0]   end_hi
);

  // bit 0 of either bound never matters, so it is not stored
  logic unused_bnd_bits;
  assign unused_bnd_bits = wdata[0] ^ wdata[MOD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_hi <= '0;
      end_hi   <= '0;
    end else if (wr) begin
      start_hi <= wdata[MOD_W-1:1];
      end_hi   <= wdata[2*MOD_W-1:MOD_W+1];
    end
  end

  // R2
  bounds_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr)) |->
      (start_hi == $past(wdata[MOD_W-1:1]) && end_hi == $past(wdata[2*MOD_W-1:MOD_W+1])));

  // R2
  bounds_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr)) |-> ($stable(start_hi) && $stable(end_hi)));

endmodule

// File: rtl/agu_lane.sv
module agu_lane
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MOD_W  = 16,
  parameter int NPTR   = 2,
  localparam int SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mv,
  input  logic [SEL_W-1:0]     sel,
  input  logic [1:0]           mode,
  input  logic [NPTR*ADDR_W-1:0] ptrs,
  input  logic [ADDR_W-1:0]    idx,
  input  logic                 mod_en,
  input  logic [MOD_W-2:0]     start_hi,
  input  logic [MOD_W-2:0]     end_hi,
  output logic [MOD_W-1:0]     addr,
  output logic [ADDR_W-1:0]    wb_data,
  output logic                 wb_en,
  output logic [SEL_W-1:0]     wb_sel,
  output logic                 wrapped
);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] p,
                                                  input logic [1:0] m,
                                                  input logic [ADDR_W-1:0] ix);
    case (upd_mode_e'(m))
      UPD_INC2:  return p + ADDR_W'(2);
      UPD_INDEX: return p + ix;
      default:   return p;
    endcase
  endfunction

  function automatic logic end_match(input logic [ADDR_W-1:0] p,
                                     input logic [MOD_W-2:0] e);
    return p[MOD_W-1:1] == e;
  endfunction

  function automatic logic [ADDR_W-1:0] reload(input logic [ADDR_W-1:0] p,
                                               input logic [MOD_W-2:0] s);
    logic [ADDR_W-1:0] r;
    r = p;
    r[MOD_W-1:1] = s;
    return r;
  endfunction

  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] stepped;
  logic              upd_req;
  logic              end_hit;
  logic              wrap_ev;

  always_comb begin
    cur = ptrs[ADDR_W-1:0];
    for (int i = 0; i < NPTR; i++) begin
      if (sel == SEL_W'(i)) cur = ptrs[i*ADDR_W +: ADDR_W];
    end
  end

  assign upd_req = mv && is_update(upd_mode_e'(mode));
  assign end_hit = end_match(cur, end_hi);
  assign wrap_ev = upd_req && mod_en && end_hit;
  assign stepped = step_addr(cur, mode, idx);

  assign addr    = cur[MOD_W-1:0];
  assign wb_data = wrap_ev ? reload(cur, start_hi) : stepped;
  assign wb_en   = upd_req;
  assign wb_sel  = sel;
  assign wrapped = wrap_ev;

  // R5
  hold_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv && !mode[0] && !mode[1]) |-> (!wb_en && !wrapped));

  // R12
  idle_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mv |-> (!wb_en && !wrapped));

  // R6
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |-> (wb_data[MOD_W-1:1] == start_hi));

  // R7
  wrap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |-> (wb_data[ADDR_W-1:MOD_W] == cur[ADDR_W-1:MOD_W] && wb_data[0] == cur[0]));

  // R9
  no_wrap_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> !wrapped);

  // R11
  addr_pre_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (addr == cur[MOD_W-1:0]));

endmodule

// File: rtl/modulo_agu.sv
module modulo_agu #(
  parameter int ADDR_W = 32,
  parameter int MOD_W  = 16,
  parameter int NPTR   = 2,
  localparam int SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bnd_wr,
  input  logic [2*MOD_W-1:0]     bnd_wdata,
  input  logic                   x_mod_en,
  input  logic                   y_mod_en,
  input  logic                   x_mv,
  input  logic [SEL_W-1:0]       x_sel,
  input  logic [1:0]             x_mode,
  input  logic [NPTR*ADDR_W-1:0] x_ptrs,
  input  logic [ADDR_W-1:0]      x_idx,
  input  logic                   y_mv,
  input  logic [SEL_W-1:0]       y_sel,
  input  logic [1:0]             y_mode,
  input  logic [NPTR*ADDR_W-1:0] y_ptrs,
  input  logic [ADDR_W-1:0]      y_idx,
  output logic [MOD_W-1:0]       x_addr,
  output logic [ADDR_W-1:0]      x_wb_data,
  output logic                   x_wb_en,
  output logic [SEL_W-1:0]       x_wb_sel,
  output logic                   x_wrap,
  output logic [MOD_W-1:0]       y_addr,
  output logic [ADDR_W-1:0]      y_wb_data,
  output logic                   y_wb_en,
  output logic [SEL_W-1:0]       y_wb_sel,
  output logic                   y_wrap
);

  logic [MOD_W-2:0] start_hi;
  logic [MOD_W-2:0] end_hi;

  modulo_bounds #(.MOD_W(MOD_W)) u_bounds (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bnd_wr),
    .wdata    (bnd_wdata),
    .start_hi (start_hi),
    .end_hi   (end_hi)
  );

  agu_lane #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .NPTR(NPTR)) u_xlane (
    .clk      (clk),
    .rst_n    (rst_n),
    .mv       (x_mv),
    .sel      (x_sel),
    .mode     (x_mode),
    .ptrs     (x_ptrs),
    .idx      (x_idx),
    .mod_en   (x_mod_en),
    .start_hi (start_hi),
    .end_hi   (end_hi),
    .addr     (x_addr),
    .wb_data  (x_wb_data),
    .wb_en    (x_wb_en),
    .wb_sel   (x_wb_sel),
    .wrapped  (x_wrap)
  );

  agu_lane #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .NPTR(NPTR)) u_ylane (
    .clk      (clk),
    .rst_n    (rst_n),
    .mv       (y_mv),
    .sel      (y_sel),
    .mode     (y_mode),
    .ptrs     (y_ptrs),
    .idx      (y_idx),
    .mod_en   (y_mod_en),
    .start_hi (start_hi),
    .end_hi   (end_hi),
    .addr     (y_addr),
    .wb_data  (y_wb_data),
    .wb_en    (y_wb_en),
    .wb_sel   (y_wb_sel),
    .wrapped  (y_wrap)
  );

  // R10
  sides_independent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_mod_en && y_mod_en && y_wb_en && y_ptrs[y_sel*ADDR_W+1 +: MOD_W-1] == end_hi) |->
      (y_wrap && !x_wrap));

endmodule

// File: tb/sim_modulo_agu.sv
`timescale 1ns/1ps
module sim_modulo_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd_wr = 1'b0;
  logic [31:0] bnd_wdata = '0;
  logic        x_mod_en = 1'b0, y_mod_en = 1'b0;
  logic        x_mv = 1'b0, y_mv = 1'b0;
  logic        x_sel = 1'b0, y_sel = 1'b0;
  logic [1:0]  x_mode = 2'b00, y_mode = 2'b00;
  logic [63:0] x_ptrs = '0, y_ptrs = '0;
  logic [31:0] x_idx = '0, y_idx = '0;
  logic [15:0] x_addr, y_addr;
  logic [31:0] x_wb_data, y_wb_data;
  logic        x_wb_en, y_wb_en, x_wb_sel, y_wb_sel, x_wrap, y_wrap;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  modulo_agu u0 (
    .clk(clk), .rst_n(rst_n), .bnd_wr(bnd_wr), .bnd_wdata(bnd_wdata),
    .x_mod_en(x_mod_en), .y_mod_en(y_mod_en),
    .x_mv(x_mv), .x_sel(x_sel), .x_mode(x_mode), .x_ptrs(x_ptrs), .x_idx(x_idx),
    .y_mv(y_mv), .y_sel(y_sel), .y_mode(y_mode), .y_ptrs(y_ptrs), .y_idx(y_idx),
    .x_addr(x_addr), .x_wb_data(x_wb_data), .x_wb_en(x_wb_en), .x_wb_sel(x_wb_sel), .x_wrap(x_wrap),
    .y_addr(y_addr), .y_wb_data(y_wb_data), .y_wb_en(y_wb_en), .y_wb_sel(y_wb_sel), .y_wrap(y_wrap)
  );

  typedef struct packed {
    logic        en;
    logic [1:0]  mode;
    logic [31:0] ptr;
    logic [31:0] idx;
    logic        we;
    logic        wrap;
    logic [31:0] res;
  } vec_t;

  // bounds for the table: end 0x100E, start 0x1000
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b01, 32'h0000_1004, 32'h0,         1'b1, 1'b0, 32'h0000_1006}, // R3
    '{1'b1, 2'b01, 32'h0000_100E, 32'h0,         1'b1, 1'b1, 32'h0000_1000}, // R6
    '{1'b1, 2'b01, 32'hABCD_100F, 32'h0,         1'b1, 1'b1, 32'hABCD_1001}, // R7 R8
    '{1'b0, 2'b01, 32'h0000_100E, 32'h0,         1'b1, 1'b0, 32'h0000_1010}, // R9
    '{1'b1, 2'b10, 32'h2000_100E, 32'h10,        1'b1, 1'b1, 32'h2000_1000}, // R4 R6
    '{1'b1, 2'b10, 32'h0000_1002, 32'h100,       1'b1, 1'b0, 32'h0000_1102}, // R4
    '{1'b1, 2'b00, 32'h0000_100E, 32'h0,         1'b0, 1'b0, 32'h0000_0000}, // R5
    '{1'b1, 2'b11, 32'h0000_100E, 32'h4,         1'b0, 1'b0, 32'h0000_0000}, // R5
    '{1'b1, 2'b01, 32'h0001_FFFE, 32'h0,         1'b1, 1'b0, 32'h0002_0000}, // R3
    '{1'b0, 2'b10, 32'h0000_100E, 32'hFFFF_FFFE, 1'b1, 1'b0, 32'h0000_100C}  // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_side(input logic side_y, input logic en, input logic mv,
                          input logic sel, input logic [1:0] mode,
                          input logic [31:0] ptr, input logic [31:0] idx);
    logic [63:0] pv;
    pv = sel ? {ptr, 32'h5A5A_5A5A} : {32'hC3C3_C3C3, ptr};
    if (side_y) begin
      y_mod_en = en; y_mv = mv; y_sel = sel; y_mode = mode; y_ptrs = pv; y_idx = idx;
    end else begin
      x_mod_en = en; x_mv = mv; x_sel = sel; x_mode = mode; x_ptrs = pv; x_idx = idx;
    end
  endtask

  task automatic check_x(input string req, input logic [31:0] ptr, input logic we,
                         input logic wr, input logic [31:0] res);
    chk({req, " x_addr R11"}, {16'h0, x_addr}, {16'h0, ptr[15:0]});
    chk({req, " x_wb_en"}, {31'h0, x_wb_en}, {31'h0, we});
    chk({req, " x_wrap"}, {31'h0, x_wrap}, {31'h0, wr});
    if (we) chk({req, " x_wb_data"}, x_wb_data, res);
  endtask

  task automatic check_y(input string req, input logic [31:0] ptr, input logic we,
                         input logic wr, input logic [31:0] res);
    chk({req, " y_addr R11"}, {16'h0, y_addr}, {16'h0, ptr[15:0]});
    chk({req, " y_wb_en"}, {31'h0, y_wb_en}, {31'h0, we});
    chk({req, " y_wrap"}, {31'h0, y_wrap}, {31'h0, wr});
    if (we) chk({req, " y_wb_data"}, y_wb_data, res);
  endtask

  task automatic write_bounds(input logic [31:0] d);
    @(negedge clk);
    bnd_wr = 1'b1; bnd_wdata = d;
    @(negedge clk);
    bnd_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset bounds are zero
    @(negedge clk);
    set_side(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 32'h0000_0000, 32'h0);
    set_side(1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 32'h0000_0002, 32'h0);
    #1;
    check_x("R1 zero bounds wrap", 32'h0, 1'b1, 1'b1, 32'h0);
    check_y("R1 zero bounds step", 32'h2, 1'b1, 1'b0, 32'h4);

    // R12: no move
    @(negedge clk);
    x_mv = 1'b0; y_mv = 1'b0;
    #1;
    chk("R12 x idle", {30'h0, x_wb_en, x_wrap}, 32'h0);
    chk("R12 y idle", {30'h0, y_wb_en, y_wrap}, 32'h0);

    // R2: old bounds in the cycle of the write, new after
    @(negedge clk);
    bnd_wr = 1'b1; bnd_wdata = {16'h100E, 16'h1000};
    set_side(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 32'h0000_100E, 32'h0);
    set_side(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 32'h0, 32'h0);
    #1;
    check_x("R2 old bounds", 32'h100E, 1'b1, 1'b0, 32'h1010);
    @(negedge clk);
    bnd_wr = 1'b0;
    #1;
    check_x("R2 new bounds", 32'h100E, 1'b1, 1'b1, 32'h1000);

    // table: X with first pointer, Y with second pointer, same vector
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_side(1'b0, VEC[i].en, 1'b1, 1'b0, VEC[i].mode, VEC[i].ptr, VEC[i].idx);
      set_side(1'b1, VEC[i].en, 1'b1, 1'b1, VEC[i].mode, VEC[i].ptr, VEC[i].idx);
      #1;
      check_x($sformatf("vec%0d R10 R13", i), VEC[i].ptr, VEC[i].we, VEC[i].wrap, VEC[i].res);
      check_y($sformatf("vec%0d R10 R13", i), VEC[i].ptr, VEC[i].we, VEC[i].wrap, VEC[i].res);
      chk("R13 x_wb_sel", {31'h0, x_wb_sel}, 32'h0);
      chk("R13 y_wb_sel", {31'h0, y_wb_sel}, 32'h1);
    end

    // R10: enables independent on the same pointer value
    @(negedge clk);
    set_side(1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 32'h0000_100E, 32'h0);
    set_side(1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 32'h0000_100E, 32'h0);
    #1;
    check_x("R10 x disabled", 32'h100E, 1'b1, 1'b0, 32'h1010);
    check_y("R10 y enabled", 32'h100E, 1'b1, 1'b1, 32'h1000);

    // R8: bit 0 set in both bounds is ignored
    write_bounds({16'h100F, 16'h1001});
    set_side(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 32'h7777_100E, 32'h0);
    set_side(1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 32'h0000_100F, 32'h8);
    #1;
    check_x("R8 odd bounds even ptr", 32'h7777_100E, 1'b1, 1'b1, 32'h7777_1000);
    check_y("R8 odd bounds odd ptr", 32'h100F, 1'b1, 1'b1, 32'h0000_1001);

    // R6: one step short of the end does not wrap
    @(negedge clk);
    set_side(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 32'h0000_100C, 32'h0);
    #1;
    check_x("R6 near end", 32'h100C, 1'b1, 1'b0, 32'h100E);

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule